// File: doc/BRIEF.md
# Serial Presence-Detect Memory Slave with Lower-Half Lock

This block is a two-wire serial bus slave in front of a 256-byte register array. It is meant to hold a memory module's configuration bytes. A master opens a transaction with a START condition and sends a select byte. The slave acknowledges only when its type code and its three chip-enable levels match. After that the master either writes bytes at an address pointer or reads bytes out in sequence.

A second type code reaches a protection function instead of the array. Through it the master can lock the lower half of the array (addresses 00h to 7Fh) against writes. The lock is either resettable or permanent. Separately, a write-control pin blocks writes to the whole array while it is high. A refused write gets no acknowledge and leaves the memory unchanged.

The bus is sampled with the system clock. The FSM states are IDLE, SEL (select byte in), SEL_ACK, ADR (address in), ADR_ACK, WDAT (data in), WDAT_ACK, CMD (lock command in), CMD_ACK, RDAT (data out) and RACK (master acknowledge). Its transitions are:
- START goes to SEL from any state, and STOP goes to IDLE from any state.
- A matching select byte leads to SEL_ACK. A refused byte in SEL, WDAT or CMD goes back to IDLE.
- SEL_ACK leads to ADR on a memory write, to RDAT on a memory read, and to CMD on a lock select.
- ADR_ACK and WDAT_ACK both lead to WDAT. CMD_ACK leads to IDLE.
- RDAT leads to RACK. RACK leads back to RDAT on an acknowledge and to IDLE on a NoAck.

Top module: `spd_lock_slave`

## Requirements
- R1: A START condition (SDA falls while SCL is high) starts a new select byte from any state. A STOP condition (SDA rises while SCL is high) returns the slave to idle with SDA released, even in the middle of a byte.
- R2: The select byte is sent MSB first. Bits 7:4 = 1010 select the array and bits 7:4 = 0110 select the lock function. Bits 3:1 must equal chip_en[2:0], and bit 0 is 1 for read. Any other code, a chip-enable mismatch, or 0110 with bit 0 = 1 gets no acknowledge, and the slave ignores the rest of the transaction.
- R3: The slave acknowledges an accepted select, address, data or command byte by setting sda_oe for the whole ninth SCL period. It releases SDA after that period ends.
- R4: In a memory write, the byte after the select byte loads the address pointer. Each later data byte is stored at the pointer, and the pointer then increments.
- R5: In a memory read, bytes are driven MSB first starting at the pointer, which increments after each byte and wraps from FFh to 00h. Reading continues while the master acknowledges and ends at a NoAck.
- R6: A write transaction that carries only the address byte sets the pointer for a following read (repeated START, then a read select).
- R7: The lock command byte 01h sets the resettable lock, 02h sets the permanent lock, and 00h clears the resettable lock. Each of these is acknowledged. Any other value is not acknowledged. A clear sent while the permanent lock is set is not acknowledged and no command clears the permanent lock.
- R8: While either lock is set, a data byte aimed at 00h–7Fh is not acknowledged and not stored. Addresses 80h–FFh stay writable.
- R9: While wc_i is high, no data byte is acknowledged or stored at any address.
- R10: After reset the slave is idle, sda_oe is low, every location reads 00h and both locks are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low |
| chip_en | input | 3 | Address levels the select byte must match |
| wc_i | input | 1 | High blocks all array writes |

## Verification
Both bus lines pass through one sampling register and are then compared with the previous sample. As a result, sda_oe changes in the second system clock after an SCL falling edge, and memory writes and pointer updates land in that same cycle. The bench holds each SCL phase for four system clocks. It reads the acknowledge and read-data bits only after SCL has been low for four clocks or high for two, so every value is settled when sampled. For refused writes, the bench reads the target address back through a later bus transaction.

// File: rtl/spd_pkg.sv
package spd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_SEL, ST_SEL_ACK, ST_ADR, ST_ADR_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_CMD, ST_CMD_ACK, ST_RDAT, ST_RACK
    } spd_state_e;

    localparam logic [3:0] CODE_ARRAY = 4'b1010;
    localparam logic [3:0] CODE_LOCK  = 4'b0110;
    localparam logic [7:0] CMD_CLEAR  = 8'h00;
    localparam logic [7:0] CMD_SOFT   = 8'h01;
    localparam logic [7:0] CMD_PERM   = 8'h02;
endpackage

// File: rtl/spd_bus_edges.sv
module spd_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_s
);
    logic scl_q, scl_p, sda_q, sda_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            scl_p <= 1'b1;
            sda_q <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            scl_p <= scl_q;
            sda_q <= sda_i;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        scl_rise  = scl_q & ~scl_p;
        scl_fall  = ~scl_q & scl_p;
        bus_start = scl_q & scl_p & sda_p & ~sda_q;
        bus_stop  = scl_q & scl_p & ~sda_p & sda_q;
        sda_s     = sda_q;
    end
endmodule

// File: rtl/spd_regfile.sv
module spd_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          lock_lo,
    input  logic          wc_i
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

    // lower half is never written while the lock is held
    assert_lo_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !waddr[AW-1]) |-> !lock_lo);
    // no write lands while the write-control pin is high
    assert_wc_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !wc_i);
endmodule

// File: rtl/spd_lock_slave.sv
module spd_lock_slave
    import spd_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_en,
    input  logic       wc_i
);
    localparam int CW = $clog2(DW + 1);

    spd_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg, obuf, rdata;
    logic [AW-1:0] ptr;
    logic          rd_dir, lock_sel, mack, soft_lock, perm_lock;
    logic          scl_rise, scl_fall, bus_start, bus_stop, sda_s;
    logic          sel_hit, wr_ok, byte_done, mem_we, cmd_ok, lock_lo;

    spd_bus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s)
    );

    spd_regfile #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(rdata), .lock_lo(lock_lo), .wc_i(wc_i)
    );

    always_comb begin
        lock_lo   = soft_lock | perm_lock;
        sel_hit   = (shreg[3:1] == chip_en);
        wr_ok     = !wc_i && (ptr[AW-1] || !lock_lo);
        byte_done = scl_fall && (cnt == CW'(DW));
        mem_we    = byte_done && (state == ST_WDAT) && wr_ok;
        unique case (shreg)
            CMD_CLEAR:         cmd_ok = !perm_lock;
            CMD_SOFT, CMD_PERM: cmd_ok = 1'b1;
            default:           cmd_ok = 1'b0;
        endcase
    end

    always_comb begin
        sda_oe = (state == ST_SEL_ACK) || (state == ST_ADR_ACK) ||
                 (state == ST_WDAT_ACK) || (state == ST_CMD_ACK) ||
                 ((state == ST_RDAT) && !obuf[DW-1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            obuf      <= '1;
            ptr       <= '0;
            rd_dir    <= 1'b0;
            lock_sel  <= 1'b0;
            mack      <= 1'b0;
            soft_lock <= 1'b0;
            perm_lock <= 1'b0;
        end else if (bus_start) begin
            state <= ST_SEL;
            cnt   <= '0;
        end else if (bus_stop) begin
            state <= ST_IDLE;
        end else begin
            if (scl_rise && (state == ST_SEL || state == ST_ADR || state == ST_WDAT ||
                             state == ST_CMD || state == ST_RDAT)) begin
                shreg <= {shreg[DW-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: ;
                ST_SEL: if (byte_done) begin
                    cnt <= '0;
                    if (sel_hit && shreg[7:4] == CODE_ARRAY) begin
                        state    <= ST_SEL_ACK;
                        rd_dir   <= shreg[0];
                        lock_sel <= 1'b0;
                    end else if (sel_hit && shreg[7:4] == CODE_LOCK && !shreg[0]) begin
                        state    <= ST_SEL_ACK;
                        rd_dir   <= 1'b0;
                        lock_sel <= 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_SEL_ACK: if (scl_fall) begin
                    if (lock_sel) state <= ST_CMD;
                    else if (rd_dir) begin
                        state <= ST_RDAT;
                        obuf  <= rdata;
                        ptr   <= ptr + 1'b1;
                    end else state <= ST_ADR;
                end
                ST_ADR: if (byte_done) begin
                    cnt   <= '0;
                    ptr   <= shreg[AW-1:0];
                    state <= ST_ADR_ACK;
                end
                ST_ADR_ACK, ST_WDAT_ACK: if (scl_fall) state <= ST_WDAT;
                ST_WDAT: if (byte_done) begin
                    cnt <= '0;
                    if (wr_ok) begin
                        ptr   <= ptr + 1'b1;
                        state <= ST_WDAT_ACK;
                    end else state <= ST_IDLE;
                end
                ST_CMD: if (byte_done) begin
                    cnt <= '0;
                    if (cmd_ok) begin
                        state <= ST_CMD_ACK;
                        if (shreg == CMD_SOFT)  soft_lock <= 1'b1;
                        if (shreg == CMD_PERM)  perm_lock <= 1'b1;
                        if (shreg == CMD_CLEAR) soft_lock <= 1'b0;
                    end else state <= ST_IDLE;
                end
                ST_CMD_ACK: if (scl_fall) state <= ST_IDLE;
                ST_RDAT: if (scl_fall) begin
                    if (cnt == CW'(DW)) begin
                        cnt   <= '0;
                        obuf  <= '1;
                        state <= ST_RACK;
                    end else obuf <= {obuf[DW-2:0], 1'b1};
                end
                ST_RACK: begin
                    if (scl_rise) mack <= !sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            state <= ST_RDAT;
                            obuf  <= rdata;
                            ptr   <= ptr + 1'b1;
                        end else state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_start_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state == ST_SEL && cnt == '0));
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start) |=> (state == ST_IDLE && !sda_oe));
    assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    assert_perm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(perm_lock));
endmodule

// File: tb/test_spd_lock_slave.sv
module test_spd_lock_slave;
    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wc = 1'b0;
    logic [2:0] ce = 3'b101;
    logic sda_oe, sda_line;
    int total = 0, bad = 0;
    bit done = 0;

    localparam logic [7:0] SEL_W  = {4'b1010, 3'b101, 1'b0};
    localparam logic [7:0] SEL_R  = {4'b1010, 3'b101, 1'b1};
    localparam logic [7:0] LOCK_W = {4'b0110, 3'b101, 1'b0};

    always #10 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    spd_lock_slave i_spd_lock_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .chip_en(ce), .wc_i(wc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; w(2); scl = 1'b1; w(4); m_sda = 1'b0; w(4); scl = 1'b0; w(2);
    endtask

    task automatic bstop();
        m_sda = 1'b0; w(4); scl = 1'b1; w(4); m_sda = 1'b1; w(4);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(4); scl = 1'b1; w(4); scl = 1'b0;
        end
        m_sda = 1'b1; w(4);
        ack = !sda_line;
        scl = 1'b1; w(4); scl = 1'b0; w(4);
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(4); scl = 1'b1; w(2); b[i] = sda_line; w(2); scl = 1'b0;
        end
        w(1); m_sda = !give_ack; w(3); scl = 1'b1; w(4); scl = 1'b0; w(1); m_sda = 1'b1;
    endtask

    task automatic mem_write(input logic [7:0] a, input logic [7:0] d, output bit dack);
        bit k;
        bstart(); send(SEL_W, k); send(a, k); send(d, dack); bstop();
    endtask

    task automatic mem_read(input logic [7:0] a, output logic [7:0] d);
        bit k;
        bstart(); send(SEL_W, k); send(a, k);
        bstart(); send(SEL_R, k); recv(1'b0, d); bstop();
    endtask

    task automatic lock_cmd(input logic [7:0] c, output bit ack);
        bit k;
        bstart(); send(LOCK_W, k); send(c, ack); bstop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(sda_oe == 1'b0, "R10 oe", sda_oe, 0);
        mem_read(8'h40, d);
        chk(d == 8'h00, "R10 mem", d, 0);
    endtask

    task automatic t_select();
        bit k;
        bstart(); send({4'b1010, 3'b100, 1'b0}, k); bstop();
        chk(!k, "R2 ce mismatch", k, 0);
        bstart(); send({4'b1110, 3'b101, 1'b0}, k); bstop();
        chk(!k, "R2 bad code", k, 0);
        bstart(); send({4'b0110, 3'b101, 1'b1}, k); bstop();
        chk(!k, "R2 lock read", k, 0);
        bstart(); send(SEL_W, k);
        chk(k, "R3 select ack", k, 1);
        w(4);
        chk(!sda_oe, "R3 release", sda_oe, 0);
        bstop();
    endtask

    task automatic t_write_read();
        bit k0, k1, k2, k3;
        logic [7:0] d0, d1;
        bstart(); send(SEL_W, k0); send(8'h90, k1); send(8'h5A, k2); send(8'hC3, k3); bstop();
        chk(k0 && k1 && k2 && k3, "R4 acks", {k0, k1, k2, k3}, 4'hF);
        mem_read(8'h91, d0);
        chk(d0 == 8'hC3, "R4 incr write", d0, 8'hC3);
        bstart(); send(SEL_W, k0); send(8'h90, k0);
        bstart(); send(SEL_R, k0); recv(1'b1, d0); recv(1'b0, d1); bstop();
        chk(d0 == 8'h5A, "R6 addr set", d0, 8'h5A);
        chk(d1 == 8'hC3, "R5 sequential", d1, 8'hC3);
    endtask

    task automatic t_wrap();
        bit k;
        logic [7:0] d0, d1;
        mem_write(8'hFF, 8'h11, k);
        mem_write(8'h00, 8'h22, k);
        bstart(); send(SEL_W, k); send(8'hFF, k);
        bstart(); send(SEL_R, k); recv(1'b1, d0); recv(1'b0, d1); bstop();
        chk(d0 == 8'h11, "R5 byte FF", d0, 8'h11);
        chk(d1 == 8'h22, "R5 wrap 00", d1, 8'h22);
    endtask

    task automatic t_stop_mid();
        bit k;
        logic [7:0] d;
        bstart();
        for (int i = 0; i < 3; i++) begin m_sda = 1'b1; w(4); scl = 1'b1; w(4); scl = 1'b0; end
        bstop();
        chk(!sda_oe, "R1 stop idle", sda_oe, 0);
        mem_write(8'h91, 8'h77, k);
        mem_read(8'h91, d);
        chk(k && d == 8'h77, "R1 after stop", d, 8'h77);
    endtask

    task automatic t_soft_lock();
        bit k;
        logic [7:0] d;
        mem_write(8'h10, 8'hAA, k);
        lock_cmd(8'h01, k);
        chk(k, "R7 set soft", k, 1);
        mem_write(8'h10, 8'h55, k);
        chk(!k, "R8 lower nack", k, 0);
        mem_read(8'h10, d);
        chk(d == 8'hAA, "R8 lower kept", d, 8'hAA);
        mem_write(8'hA0, 8'h66, k);
        mem_read(8'hA0, d);
        chk(k && d == 8'h66, "R8 upper ok", d, 8'h66);
        lock_cmd(8'h37, k);
        chk(!k, "R7 bad cmd", k, 0);
        lock_cmd(8'h00, k);
        chk(k, "R7 clear soft", k, 1);
        mem_write(8'h10, 8'h55, k);
        mem_read(8'h10, d);
        chk(k && d == 8'h55, "R7 cleared", d, 8'h55);
    endtask

    task automatic t_wc();
        bit k;
        logic [7:0] d;
        wc = 1'b1;
        mem_write(8'hA0, 8'h99, k);
        chk(!k, "R9 nack", k, 0);
        wc = 1'b0;
        mem_read(8'hA0, d);
        chk(d == 8'h66, "R9 kept", d, 8'h66);
    endtask

    task automatic t_perm();
        bit k;
        logic [7:0] d;
        lock_cmd(8'h02, k);
        chk(k, "R7 set perm", k, 1);
        lock_cmd(8'h00, k);
        chk(!k, "R7 clear refused", k, 0);
        mem_write(8'h05, 8'h3C, k);
        mem_read(8'h05, d);
        chk(!k && d == 8'h00, "R7 perm holds", d, 0);
    endtask

    initial begin
        w(5); rst_n = 1'b1; w(5);
        t_reset();
        t_select();
        t_write_read();
        t_wrap();
        t_stop_mid();
        t_soft_lock();
        t_wc();
        t_perm();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule